// File: doc/BRIEF.md
# Geometric-History Tagged Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A direct-mapped table of 2-bit counters, indexed by the branch address, gives a default guess. On top of it sit several partially tagged tables. Each one is indexed and tagged by a hash of the branch address and a prefix of the global outcome history, and the prefix lengths grow geometrically from table to table. Short-history tables learn branches that depend on recent neighbours. Long-history tables learn branches that depend on outcomes far back. When one or more tagged tables match, the one with the longest history gives the answer. When none match, the default table answers.

The front end presents a branch address on `brPc` and reads `predTaken` in the same cycle. When that branch resolves, before any later branch is looked up, the front end holds the same address and pulses `resValid` with the real outcome on `resTaken`. The block recomputes the lookup from its current state and then applies the update on that clock edge. The update trains the answering counter, adjusts usefulness, allocates a longer-history entry when the guess was wrong, and shifts the outcome into the history. With the default parameters (a 4096-entry default table and four 1024-entry tagged tables with 9-bit tags, history lengths 5, 12, 30 and 75) the storage is about 8 KB.

Top module: `geo_hist_predictor`

## Requirements
- R1: After reset, every default counter holds 1 (binary 01), every tagged entry is invalid with counter 0 and usefulness 0, the history is all zeros, and every address is predicted not-taken.
- R2: The default table index is address bits [BASE_IDX_W+1:2]. Its guess is the counter's upper bit. On a resolve with no tagged hit, that counter moves one step toward the outcome and saturates at 0 and 3.
- R3: Each resolve shifts its outcome into history bit 0, and older bits move up by one. Tagged table t (t = 0 for the shortest) uses the newest L_t history bits. L_t is the largest integer x with x^(N-1) <= MIN_HIST^(N-1-t) * MAX_HIST^t, where N is the number of tagged tables.
- R4: With fold(L,W) setting bit k to the XOR of history bits j < L where j mod W = k, the index of table t is pc[2 +: IW] ^ pc[2+IW +: IW] ^ fold(L_t,IW). Its tag is (pc[2 +: TW] ^ fold(L_t,TW) ^ (fold(L_t,TW-1) << 1)) truncated to TW bits. A hit needs a valid entry whose stored tag equals the computed tag.
- R5: The provider is the highest-numbered table that hits. A tagged 3-bit two's-complement counter predicts taken when it is >= 0. The output is the provider's guess, or the default guess when nothing hits. The alternate guess is that of the next lower hitting table, or the default guess.
- R6: On a resolve with a provider, the provider's counter moves one step toward the outcome and saturates at -4 and +3. The default counter is left unchanged.
- R7: When the provider's guess and the alternate guess differ, the provider's 2-bit usefulness counter goes up on a correct guess and down on a wrong one, saturating at 0 and 3.
- R8: On a wrong output, the lowest-numbered table above the provider (above none when there is no provider) whose indexed entry has usefulness 0 is allocated. The entry becomes valid, takes the computed tag, gets usefulness 0, and gets counter 0 if taken or -1 if not.
- R9: On a wrong output where every table above the provider has usefulness other than 0 at its indexed entry, each of those entries has its usefulness decremented (floor 0) and nothing is allocated.
- R10: On every 2^AGE_LOG2-th resolve since reset, every usefulness counter in every tagged table is halved (shift right by one). This happens after that resolve's own update.
- R11: While `resValid` is low, no table and no history bit changes, whatever the values of `brPc` and `resTaken`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| brPc | input | PC_W | Address of the branch being looked up or resolved |
| predTaken | output | 1 | Guess for `brPc` from the current state (combinational) |
| resValid | input | 1 | The branch at `brPc` resolves on this edge |
| resTaken | input | 1 | Actual outcome of the resolving branch |

## Verification
`predTaken` depends only on `brPc` and the stored state, so it is valid in the same cycle the address is applied. The effects of a resolve, on the tables, the history and the aging count, show up only after the rising edge on which `resValid` is sampled high. The bench changes its inputs on the falling edge and reads the guess one nanosecond later. At that point the guess must reflect every resolve up to the previous rising edge and none after it. Its reference model applies each resolve at that same edge, so every comparison uses state that is exactly one rising edge old.

// File: rtl/geohist_pkg.sv
package geohist_pkg;

  // Widest table selector; NUM_TAGGED must not exceed 2**SEL_W.
  localparam int unsigned SEL_W = 3;

  typedef struct packed {
    logic             baseWr;
    logic             provWr;
    logic             useInc;
    logic             useDec;
    logic             allocEn;
    logic [SEL_W-1:0] allocSel;
    logic             decayEn;
    logic [SEL_W:0]   floorSel;
    logic             ageAll;
    logic             histShift;
    logic             taken;
  } strobe_t;

endpackage

// File: rtl/ghp_datapath.sv
module ghp_datapath
  import geohist_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int BASE_IDX_W = 12,
  parameter int TAG_IDX_W  = 10,
  parameter int TAG_W      = 9,
  parameter int NUM_TAGGED = 4,
  parameter int MIN_HIST   = 5,
  parameter int MAX_HIST   = 75,
  parameter int HIST_W     = 75
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PC_W-1:0]       brPc,
  input  strobe_t               stb,
  output logic                  basePred,
  output logic                  provHit,
  output logic [SEL_W-1:0]      provSel,
  output logic                  provPred,
  output logic                  altPred,
  output logic [NUM_TAGGED-1:0] uZero
);

  localparam int BASE_DEPTH = 1 << BASE_IDX_W;
  localparam int TAG_DEPTH  = 1 << TAG_IDX_W;

  // Largest x with x^(n-1) <= mn^(n-1-t) * mx^t.
  function automatic int histLen(int t, int n, int mn, int mx);
    longint lim;
    longint p;
    int x;
    if (n < 2) return mx;
    lim = 1;
    for (int k = 0; k < n - 1; k++) lim = lim * ((k < n - 1 - t) ? mn : mx);
    x = 1;
    for (int c = 2; c <= mx; c++) begin
      p = 1;
      for (int k = 0; k < n - 1; k++) p = p * c;
      if (p <= lim) x = c;
    end
    return x;
  endfunction

  function automatic logic [31:0] foldHist(logic [HIST_W-1:0] h, int len, int w);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < HIST_W; j++)
      if (j < len) r[j % w] = r[j % w] ^ h[j];
    return r;
  endfunction

  function automatic logic [1:0] uHalf(logic [1:0] v, logic age);
    return age ? {1'b0, v[1]} : v;
  endfunction

  logic [HIST_W-1:0] ghist;
  logic              pcUnused;
  assign pcUnused = ^brPc;

  always_ff @(posedge clk) begin
    if (!rstN) ghist <= '0;
    else if (stb.histShift) ghist <= {ghist[HIST_W-2:0], stb.taken};
  end

  // Default table
  logic [1:0]            baseMem [BASE_DEPTH];
  logic [BASE_IDX_W-1:0] baseIdx;
  logic [1:0]            baseCur, baseUpd;
  assign baseIdx  = brPc[2 +: BASE_IDX_W];
  assign baseCur  = baseMem[baseIdx];
  assign basePred = baseCur[1];
  assign baseUpd  = stb.taken ? ((baseCur == 2'd3) ? baseCur : baseCur + 2'd1)
                              : ((baseCur == 2'd0) ? baseCur : baseCur - 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < BASE_DEPTH; e++) baseMem[e] <= 2'b01;
    end else if (stb.baseWr) begin
      baseMem[baseIdx] <= baseUpd;
    end
  end

  // Tagged tables
  logic [NUM_TAGGED-1:0] hitVec;
  logic [NUM_TAGGED-1:0] tPred;

  for (genvar t = 0; t < NUM_TAGGED; t++) begin : g_tbl
    localparam int LEN = histLen(t, NUM_TAGGED, MIN_HIST, MAX_HIST);

    logic                 validMem [TAG_DEPTH];
    logic [TAG_W-1:0]     tagMem   [TAG_DEPTH];
    logic [2:0]           ctrMem   [TAG_DEPTH];
    logic [1:0]           uMem     [TAG_DEPTH];
    logic [TAG_IDX_W-1:0] idx;
    logic [TAG_W-1:0]     tag;
    logic [2:0]           ctrCur, ctrUpd;
    logic [1:0]           uCur, uInc, uDec;
    logic                 provThis, aboveThis;

    assign idx = brPc[2 +: TAG_IDX_W] ^ brPc[2 + TAG_IDX_W +: TAG_IDX_W]
               ^ TAG_IDX_W'(foldHist(ghist, LEN, TAG_IDX_W));
    assign tag = brPc[2 +: TAG_W] ^ TAG_W'(foldHist(ghist, LEN, TAG_W))
               ^ TAG_W'(foldHist(ghist, LEN, TAG_W - 1) << 1);

    assign ctrCur    = ctrMem[idx];
    assign uCur      = uMem[idx];
    assign hitVec[t] = validMem[idx] && (tagMem[idx] == tag);
    assign tPred[t]  = !ctrCur[2];
    assign uZero[t]  = (uCur == 2'd0);
    assign ctrUpd    = stb.taken ? ((ctrCur == 3'b011) ? ctrCur : ctrCur + 3'd1)
                                 : ((ctrCur == 3'b100) ? ctrCur : ctrCur - 3'd1);
    assign uInc      = (uCur == 2'd3) ? uCur : uCur + 2'd1;
    assign uDec      = (uCur == 2'd0) ? uCur : uCur - 2'd1;
    assign provThis  = (provSel == SEL_W'(t));
    assign aboveThis = ((SEL_W + 1)'(t) >= stb.floorSel);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < TAG_DEPTH; e++) begin
          validMem[e] <= 1'b0;
          tagMem[e]   <= '0;
          ctrMem[e]   <= '0;
          uMem[e]     <= '0;
        end
      end else begin
        if (stb.ageAll)
          for (int e = 0; e < TAG_DEPTH; e++) uMem[e] <= {1'b0, uMem[e][1]};
        if (stb.provWr && provThis) ctrMem[idx] <= ctrUpd;
        if ((stb.useInc || stb.useDec) && provThis)
          uMem[idx] <= uHalf(stb.useInc ? uInc : uDec, stb.ageAll);
        if (stb.allocEn && (stb.allocSel == SEL_W'(t))) begin
          validMem[idx] <= 1'b1;
          tagMem[idx]   <= tag;
          ctrMem[idx]   <= stb.taken ? 3'b000 : 3'b111;
          uMem[idx]     <= 2'd0;
        end
        if (stb.decayEn && aboveThis) uMem[idx] <= uHalf(uDec, stb.ageAll);
      end
    end
  end

  // Longest hit wins; the previous winner becomes the alternate.
  always_comb begin
    provHit  = 1'b0;
    provSel  = '0;
    provPred = basePred;
    altPred  = basePred;
    for (int t = 0; t < NUM_TAGGED; t++) begin
      if (hitVec[t]) begin
        altPred  = provPred;
        provPred = tPred[t];
        provSel  = SEL_W'(t);
        provHit  = 1'b1;
      end
    end
  end

  a_r3_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    stb.histShift |=> (ghist[HIST_W-1:1] == $past(ghist[HIST_W-2:0])) && (ghist[0] == $past(stb.taken)));
  a_r11_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.histShift |=> $stable(ghist));
  a_r5_longest_hit: assert property (@(posedge clk) disable iff (!rstN)
    provHit |-> ((hitVec >> (provSel + 1'b1)) == '0));
  a_r5_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !provHit |-> (hitVec == '0));
  a_r8_alloc_above_provider: assert property (@(posedge clk) disable iff (!rstN)
    stb.allocEn |-> (!provHit || (stb.allocSel > provSel)));
  a_r8_alloc_free_slot: assert property (@(posedge clk) disable iff (!rstN)
    stb.allocEn |-> uZero[stb.allocSel]);
  a_r9_decay_all_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.decayEn |-> ((uZero >> stb.floorSel) == '0));

endmodule

// File: rtl/ghp_control.sv
module ghp_control
  import geohist_pkg::*;
#(
  parameter int NUM_TAGGED = 4,
  parameter int AGE_LOG2   = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  input  logic                  resTaken,
  input  logic                  basePred,
  input  logic                  provHit,
  input  logic [SEL_W-1:0]      provSel,
  input  logic                  provPred,
  input  logic                  altPred,
  input  logic [NUM_TAGGED-1:0] uZero,
  output logic                  predTaken,
  output strobe_t               stb
);

  logic [AGE_LOG2-1:0]   ageCnt;
  logic                  mispred;
  logic [SEL_W:0]        floorSel;
  logic [NUM_TAGGED-1:0] cand;
  logic [SEL_W-1:0]      firstFree;

  assign predTaken = provHit ? provPred : basePred;
  assign mispred   = resValid && (predTaken != resTaken);
  assign floorSel  = provHit ? ({1'b0, provSel} + 1'b1) : '0;

  always_comb begin
    firstFree = '0;
    for (int j = 0; j < NUM_TAGGED; j++)
      cand[j] = uZero[j] && ((SEL_W + 1)'(j) >= floorSel);
    for (int j = NUM_TAGGED - 1; j >= 0; j--)
      if (cand[j]) firstFree = SEL_W'(j);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ageCnt <= '0;
    else if (resValid) ageCnt <= ageCnt + 1'b1;
  end

  always_comb begin
    stb           = '0;
    stb.taken     = resTaken;
    stb.histShift = resValid;
    stb.baseWr    = resValid && !provHit;
    stb.provWr    = resValid && provHit;
    stb.useInc    = resValid && provHit && (provPred != altPred) && (provPred == resTaken);
    stb.useDec    = resValid && provHit && (provPred != altPred) && (provPred != resTaken);
    stb.floorSel  = floorSel;
    stb.allocSel  = firstFree;
    stb.allocEn   = mispred && (cand != '0);
    stb.decayEn   = mispred && (cand == '0) && (floorSel < (SEL_W + 1)'(NUM_TAGGED));
    stb.ageAll    = resValid && (&ageCnt);
  end

  a_r8_alloc_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    stb.allocEn |-> (resValid && (predTaken != resTaken)));
  a_r10_age_spacing: assert property (@(posedge clk) disable iff (!rstN)
    stb.ageAll |=> !stb.ageAll);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !(stb.baseWr || stb.provWr || stb.allocEn || stb.decayEn || stb.ageAll));

endmodule

// File: rtl/geo_hist_predictor.sv
module geo_hist_predictor
  import geohist_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int BASE_IDX_W = 12,
  parameter int TAG_IDX_W  = 10,
  parameter int TAG_W      = 9,
  parameter int NUM_TAGGED = 4,
  parameter int MIN_HIST   = 5,
  parameter int MAX_HIST   = 75,
  parameter int HIST_W     = 75,
  parameter int AGE_LOG2   = 18
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] brPc,
  output logic            predTaken,
  input  logic            resValid,
  input  logic            resTaken
);

  strobe_t               stb;
  logic                  basePred, provHit, provPred, altPred;
  logic [SEL_W-1:0]      provSel;
  logic [NUM_TAGGED-1:0] uZero;

  ghp_datapath #(
    .PC_W(PC_W), .BASE_IDX_W(BASE_IDX_W), .TAG_IDX_W(TAG_IDX_W), .TAG_W(TAG_W),
    .NUM_TAGGED(NUM_TAGGED), .MIN_HIST(MIN_HIST), .MAX_HIST(MAX_HIST), .HIST_W(HIST_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .brPc(brPc), .stb(stb),
    .basePred(basePred), .provHit(provHit), .provSel(provSel),
    .provPred(provPred), .altPred(altPred), .uZero(uZero)
  );

  ghp_control #(
    .NUM_TAGGED(NUM_TAGGED), .AGE_LOG2(AGE_LOG2)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resTaken(resTaken),
    .basePred(basePred), .provHit(provHit), .provSel(provSel),
    .provPred(provPred), .altPred(altPred), .uZero(uZero),
    .predTaken(predTaken), .stb(stb)
  );

endmodule

// File: tb/geo_hist_predictor_tb_top.sv
`timescale 1ns/1ps
module geo_hist_predictor_tb_top;

  localparam int PCW = 16, BW = 4, IW = 3, TW = 5, NT = 3, HW = 8, AGEN = 64;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [PCW-1:0] brPc = '0;
  logic           predTaken;
  logic           resValid = 1'b0;
  logic           resTaken = 1'b0;

  always #4 clk = ~clk;

  geo_hist_predictor #(
    .PC_W(PCW), .BASE_IDX_W(BW), .TAG_IDX_W(IW), .TAG_W(TW), .NUM_TAGGED(NT),
    .MIN_HIST(2), .MAX_HIST(8), .HIST_W(HW), .AGE_LOG2(6)
  ) dut_i (
    .clk(clk), .rstN(rstN), .brPc(brPc), .predTaken(predTaken),
    .resValid(resValid), .resTaken(resTaken)
  );

  int total = 0, bad = 0;

  // Reference state
  int        mBase [1 << BW];
  bit        mVal  [NT][1 << IW];
  int        mTag  [NT][1 << IW];
  int        mCtr  [NT][1 << IW];
  int        mU    [NT][1 << IW];
  logic [HW-1:0] mHist;
  int        mAge;
  int        lenT [NT] = '{2, 4, 8};  // R3 lengths for MIN 2, MAX 8, three tables

  int  kIdx [NT];
  int  kTag [NT];
  bit  kHit [NT];
  int  kBi, kProv;
  bit  kProvPred, kAltPred, kBasePred, kFinal;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fold(logic [HW-1:0] h, int len, int w);
    int r = 0;
    for (int j = 0; j < len; j++) if (h[j]) r = r ^ (1 << (j % w));
    return r;
  endfunction

  task automatic modelReset();
    for (int e = 0; e < (1 << BW); e++) mBase[e] = 1;
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < (1 << IW); e++) begin
        mVal[t][e] = 0; mTag[t][e] = 0; mCtr[t][e] = 0; mU[t][e] = 0;
      end
    mHist = '0;
    mAge = 0;
  endtask

  task automatic modelLookup(input int pc);
    kBi = (pc >> 2) & ((1 << BW) - 1);
    kBasePred = (mBase[kBi] >= 2);
    kProv = -1;
    kProvPred = kBasePred;
    kAltPred = kBasePred;
    for (int t = 0; t < NT; t++) begin
      kIdx[t] = ((pc >> 2) ^ (pc >> (2 + IW)) ^ fold(mHist, lenT[t], IW)) & ((1 << IW) - 1);
      kTag[t] = ((pc >> 2) ^ fold(mHist, lenT[t], TW) ^ (fold(mHist, lenT[t], TW - 1) << 1))
                & ((1 << TW) - 1);
      kHit[t] = mVal[t][kIdx[t]] && (mTag[t][kIdx[t]] == kTag[t]);
      if (kHit[t]) begin
        kAltPred = kProvPred;
        kProvPred = (mCtr[t][kIdx[t]] >= 0);
        kProv = t;
      end
    end
    kFinal = (kProv >= 0) ? kProvPred : kBasePred;
  endtask

  task automatic modelUpdate(input bit tk);
    int fl;
    int sel;
    if (kProv >= 0) begin
      if (tk && mCtr[kProv][kIdx[kProv]] < 3) mCtr[kProv][kIdx[kProv]]++;
      if (!tk && mCtr[kProv][kIdx[kProv]] > -4) mCtr[kProv][kIdx[kProv]]--;
      if (kProvPred != kAltPred) begin
        if (kProvPred == tk) begin
          if (mU[kProv][kIdx[kProv]] < 3) mU[kProv][kIdx[kProv]]++;
        end else if (mU[kProv][kIdx[kProv]] > 0) mU[kProv][kIdx[kProv]]--;
      end
    end else begin
      if (tk && mBase[kBi] < 3) mBase[kBi]++;
      if (!tk && mBase[kBi] > 0) mBase[kBi]--;
    end
    if (kFinal != tk) begin
      fl = kProv + 1;
      sel = -1;
      for (int t = NT - 1; t >= fl; t--) if (mU[t][kIdx[t]] == 0) sel = t;
      if (sel >= 0) begin
        mVal[sel][kIdx[sel]] = 1;
        mTag[sel][kIdx[sel]] = kTag[sel];
        mCtr[sel][kIdx[sel]] = tk ? 0 : -1;
        mU[sel][kIdx[sel]] = 0;
      end else begin
        for (int t = fl; t < NT; t++) if (mU[t][kIdx[t]] > 0) mU[t][kIdx[t]]--;
      end
    end
    mAge++;
    if (mAge == AGEN) begin
      mAge = 0;
      for (int t = 0; t < NT; t++)
        for (int e = 0; e < (1 << IW); e++) mU[t][e] = mU[t][e] >> 1;
    end
    mHist = {mHist[HW-2:0], tk};
  endtask

  // One resolve per cycle; guess checked before the edge that applies it.
  task automatic step(input int pc, input bit tk, input string req);
    brPc = PCW'(pc);
    resValid = 1'b1;
    resTaken = tk;
    #1;
    modelLookup(pc);
    chk(predTaken == kFinal, req, int'(predTaken), int'(kFinal));
    modelUpdate(tk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int pcs [8] = '{16'h0100, 16'h0104, 16'h02a8, 16'h03fc, 16'h1234, 16'h0a40, 16'h7ff0, 16'h0018};
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state predicts not-taken everywhere
    for (int i = 0; i < 64; i++) begin
      brPc = PCW'(i * 4 + (i << 8));
      #1;
      chk(predTaken == 1'b0, "R1 reset guess", int'(predTaken), 0);
    end

    // R11: idle cycles with toggling inputs change nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      brPc = PCW'(i * 52);
      resTaken = i[0];
      resValid = 1'b0;
    end
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      brPc = PCW'(i * 52);
      #1;
      chk(predTaken == 1'b0, "R11 idle no effect", int'(predTaken), 0);
    end
    @(negedge clk);

    // R2: default counter training with not-taken then taken
    for (int i = 0; i < 4; i++) step(16'h0040, 1'b0, "R2 default counter");
    for (int i = 0; i < 12; i++) step(16'h0040, 1'b1, "R2/R6 counters");

    // R3 R4 R5: alternating outcome on one branch
    for (int i = 0; i < 200; i++) step(16'h0100, i[0], "R3 R4 R5 history match");

    // R6 R7 R8: loop-like branch interleaved with a correlated one
    for (int i = 0; i < 300; i++) begin
      step(16'h02a8, (i % 4) != 3, "R6 R7 R8 loop pattern");
      step(16'h03fc, (i % 4) == 3, "R7 R8 correlated");
    end

    // R8 R9 R10: pseudo-random outcomes on several branches
    lfsr = 16'hace1;
    for (int i = 0; i < 1200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(pcs[lfsr[2:0]], lfsr[5] ^ lfsr[9], "R8 R9 R10 mixed");
    end

    // R11 again after training: idle cycles leave all guesses as the model has them
    resValid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      brPc = PCW'(pcs[i % 8]);
      resTaken = ~i[0];
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      brPc = PCW'(pcs[i]);
      #1;
      modelLookup(pcs[i]);
      chk(predTaken == kFinal, "R11 trained idle", int'(predTaken), int'(kFinal));
    end

    summary();
    $finish;
  end

endmodule